// File: doc/BRIEF.md
# Two-Player Lamp Ping-Pong Controller

This block runs a two-player ping-pong game on a row of eight lamps. While a rally is in progress exactly one lamp is lit, and that lamp is the ball. The ball moves one lamp per step. A step happens once every N pulses of the external movement tick, and N is the current ball rate. Each player has one paddle button at their own end of the row. A player who presses while the ball sits on their end lamp sends it back. If that player presses too soon, or does not press before the ball leaves the end, the ball goes out and the other player scores.

While no ball is in play, the lamp row shows the two 4-bit scores. Only the player who scored last can serve the next ball. The ball starts from the server's end and travels toward the opponent at the slow rate. On each return the new rate depends on how late the return was: the later the return, the faster the ball goes back.

The tick is expected to pulse for one clock cycle, about four times a second. The buttons are expected to be debounced already.

Top module: `pingpong_game`

## Requirements
- R1: After reset both scores are zero and no ball is in play. The lamps show the scores, so all are dark. The left player holds the serve.
- R2: While a ball is in play exactly one lamp is lit. Lamp bit 7 is the left end and lamp bit 0 is the right end.
- R3: While in play, the ball moves one lamp toward its direction of travel on every N-th tick pulse. N is 4 at the slow rate, 2 at the mid rate and 1 at the fast rate, counted from the moment the ball arrived at its lamp.
- R4: A button acts only on the clock cycle in which it goes from released to pressed. Holding it down has no further effect.
- R5: A press by the player the ball is moving toward, while the ball is on that player's end lamp, reverses the direction. The ball stays on that lamp until its next step.
- R6: A press by the player the ball is moving toward, while the ball is not yet on that player's end lamp, ends the rally. The other player's score goes up by one.
- R7: If the ball is due to step off the end lamp of the player it is moving toward and that player has not pressed, the rally ends. The other player's score goes up by one.
- R8: While no ball is in play, only the player who scored last serves (the left player after reset), and a press by the other player is ignored. A serve lights that player's end lamp, sends the ball toward the opponent and uses the slow rate.
- R9: Each score is a 4-bit counter. While no ball is in play the lamps show the left score in bits 7..4 and the right score in bits 3..0.
- R10: On a return, k is the number of tick pulses the ball has spent on the end lamp. If k equals N-1 the new rate is fast. If k is 0 and not N-1 the new rate is slow. Any other k gives the mid rate.
- R11: A press by the player the ball is moving away from has no effect on the ball or the scores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle movement tick pulse |
| btn_l | input | 1 | Left player paddle button, high when pressed |
| btn_r | input | 1 | Right player paddle button, high when pressed |
| lamps | output | 8 | Ball position in play, scores when idle |
| score_l | output | 4 | Left player score |
| score_r | output | 4 | Right player score |

## Verification
The assertions assume that `tick` is a single-cycle pulse and never arrives on the same cycle as a paddle press. Under that assumption, every change of the ball can be traced to exactly one cause: a step, a return or a serve. The stimulus drives inputs half a period away from the active edge. It pulses the tick for one cycle at a time and releases each button for at least one cycle before pressing it again, except in the deliberate held-button case. Presses and ticks always fall on separate cycles.

// File: rtl/pingpong_game.sv
module pingpong_game #(
  parameter int NLAMP      = 8,
  parameter int SLOW_TICKS = 4,
  parameter int MID_TICKS  = 2,
  parameter int FAST_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             btn_l,
  input  logic             btn_r,
  output logic [NLAMP-1:0] lamps,
  output logic [NLAMP/2-1:0] score_l,
  output logic [NLAMP/2-1:0] score_r
);
  localparam int SW = NLAMP / 2;
  localparam int CW = $clog2(SLOW_TICKS + 1);

  logic             prev_l, prev_r;
  logic             in_play, dir_left, server_left;
  logic [NLAMP-1:0] ball;
  logic [CW-1:0]    cnt, period, new_period;

  wire edge_l   = btn_l & ~prev_l;
  wire edge_r   = btn_r & ~prev_r;
  wire at_goal  = dir_left ? ball[NLAMP-1] : ball[0];
  wire approach = dir_left ? edge_l : edge_r;
  wire last_cnt = (cnt == period - CW'(1));
  wire step     = tick & last_cnt;
  wire hit      = in_play & approach & at_goal;
  wire early    = in_play & approach & ~at_goal;
  wire leave    = in_play & step & at_goal & ~approach;
  wire miss     = early | leave;
  wire serve    = ~in_play & (server_left ? edge_l : edge_r);

  assign new_period = last_cnt ? CW'(FAST_TICKS) :
                      (cnt == '0) ? CW'(SLOW_TICKS) : CW'(MID_TICKS);

  assign lamps = in_play ? ball : {score_l, score_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l      <= 1'b0;
      prev_r      <= 1'b0;
      in_play     <= 1'b0;
      dir_left    <= 1'b0;
      server_left <= 1'b1;
      ball        <= '0;
      cnt         <= '0;
      period      <= CW'(SLOW_TICKS);
      score_l     <= '0;
      score_r     <= '0;
    end else begin
      prev_l <= btn_l;
      prev_r <= btn_r;
      if (serve) begin
        in_play  <= 1'b1;
        ball     <= server_left ? {1'b1, {(NLAMP-1){1'b0}}} : NLAMP'(1);
        dir_left <= ~server_left;
        cnt      <= '0;
        period   <= CW'(SLOW_TICKS);
      end else if (miss) begin
        in_play <= 1'b0;
        ball    <= '0;
        if (dir_left) begin
          score_r     <= score_r + SW'(1);
          server_left <= 1'b0;
        end else begin
          score_l     <= score_l + SW'(1);
          server_left <= 1'b1;
        end
      end else if (hit) begin
        dir_left <= ~dir_left;
        cnt      <= '0;
        period   <= new_period;
      end else if (in_play && tick) begin
        if (last_cnt) begin
          cnt  <= '0;
          ball <= dir_left ? (ball << 1) : (ball >> 1);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assert_one_lamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_play |-> $countones(ball) == 1);

  assert_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_play && $past(in_play) && ball != $past(ball)) |-> $past(tick));

  assert_move_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_play && $past(in_play) && ball != $past(ball)) |->
      (ball == ($past(ball) << 1) || ball == ($past(ball) >> 1)));

  assert_serve_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_play) |-> (ball[NLAMP-1] || ball[0]));

  assert_one_point_per_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_play) |->
      ((score_l == $past(score_l) + SW'(1) && score_r == $past(score_r)) ||
       (score_r == $past(score_r) + SW'(1) && score_l == $past(score_l))));

  assert_scores_hold_in_play_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_play && $past(in_play)) |-> ($stable(score_l) && $stable(score_r)));
endmodule

// File: tb/pingpong_game_test.sv
`timescale 1ns/1ps
module pingpong_game_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, btn_l = 1'b0, btn_r = 1'b0;
  logic [7:0] lamps;
  logic [3:0] score_l, score_r;
  int total = 0, bad = 0;
  bit done = 1'b0;

  pingpong_game uut (.clk(clk), .rst_n(rst_n), .tick(tick), .btn_l(btn_l),
                     .btn_r(btn_r), .lamps(lamps), .score_l(score_l), .score_r(score_r));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic press_l();
    @(negedge clk) btn_l = 1'b1;
    @(negedge clk) btn_l = 1'b0;
  endtask

  task automatic press_r();
    @(negedge clk) btn_r = 1'b1;
    @(negedge clk) btn_r = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 lamps", lamps, 8'h00);
    check("R1 score_l", {4'h0, score_l}, 8'h00);
    check("R1 score_r", {4'h0, score_r}, 8'h00);
  endtask

  task automatic t_serve_slow();
    press_r();
    check("R8 non-server ignored", lamps, 8'h00);
    press_l();
    check("R8 left serve", lamps, 8'h80);
    ticks(3);
    check("R3 slow hold", lamps, 8'h80);
    ticks(1);
    check("R3 slow step", lamps, 8'h40);
    check("R2 single lamp", 8'($countones(lamps)), 8'd1);
    ticks(24);
    check("R3 reach right end", lamps, 8'h01);
  endtask

  task automatic t_mid_return();
    ticks(1);
    press_r();
    check("R5 stays on end", lamps, 8'h01);
    ticks(1);
    check("R10 mid hold", lamps, 8'h01);
    ticks(1);
    check("R10 mid step", lamps, 8'h02);
    ticks(12);
    check("R3 reach left end", lamps, 8'h80);
  endtask

  task automatic t_fast_then_early();
    ticks(1);
    press_l();
    ticks(1);
    check("R10 fast step", lamps, 8'h40);
    press_l();
    check("R11 away press ignored", lamps, 8'h40);
    ticks(5);
    check("R3 fast travel", lamps, 8'h02);
    press_r();
    check("R6 early miss lamps", lamps, 8'h10);
    check("R6 left scored", {4'h0, score_l}, 8'h01);
  endtask

  task automatic t_held_button();
    press_r();
    check("R8 only scorer serves", lamps, 8'h10);
    @(negedge clk) btn_l = 1'b1;
    @(negedge clk);
    check("R8 serve again", lamps, 8'h80);
    ticks(28);
    check("R3 right end again", lamps, 8'h01);
    press_r();
    ticks(28);
    check("R4 held at left end", lamps, 8'h80);
    ticks(3);
    check("R4 held no return", lamps, 8'h80);
    ticks(1);
    check("R7 miss after leave", lamps, 8'h11);
    @(negedge clk) btn_l = 1'b0;
  endtask

  task automatic t_right_serve_no_press();
    press_l();
    check("R8 left cannot serve", lamps, 8'h11);
    press_r();
    check("R8 right serve", lamps, 8'h01);
    press_r();
    check("R11 server press ignored", lamps, 8'h01);
    ticks(4);
    check("R8 toward left", lamps, 8'h02);
    ticks(24);
    check("R3 at left end", lamps, 8'h80);
    ticks(4);
    check("R7 left missed", lamps, 8'h12);
    check("R9 right score", {4'h0, score_r}, 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serve_slow();
    t_mid_return();
    t_fast_then_early();
    t_held_button();
    t_right_serve_no_press();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule